// File: doc/BRIEF.md
# Fetch Program Counter with Redirect

This block holds the fetch address of a five-stage 32-bit pipeline. Every cycle it presents a word address and an enable to instruction memory, and moves on by one 4-byte instruction. A redirect request arriving with a 32-bit target makes fetch continue from that target on the next cycle. A stall input freezes the address. While reset is high, fetch is idle.

A combinational target helper sits beside the counter. It takes an instruction word, the address of that instruction and the two compared register values. It reports whether the word asks for a change of flow, the target it computes, and the link write that a call-style jump carries. In the pipeline the decode stage feeds these outputs back as the redirect request. The helper can also be tested on its own.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `imem_en_o` is 0 and `imem_addr_o` equals the reset address (default 0).
- R2: On the first edge with `rst` low, `imem_en_o` becomes 1 and `imem_addr_o` stays at the reset address. Redirect and stall have no effect on that edge.
- R3: While running, with `redir_i` and `stall_i` low, the address increases by 4 at each edge, wrapping modulo 2^32.
- R4: While running, `redir_i` high at an edge loads `redir_tgt_i` into the address. This wins over a stall that is high in the same cycle.
- R5: While running, `stall_i` high with `redir_i` low keeps the address unchanged.
- R6: An instruction word with bits 31:26 = 000010 gives `calc_redir_o`=1 and `calc_tgt_o` = {bits 31:28 of (`dec_pc_i`+4), word bits 25:0, 2'b00}, with `link_wr_o`=0.
- R7: A word with bits 31:26 = 000011 gives the same redirect and target as R6, plus `link_wr_o`=1, `link_val_o`=`dec_pc_i`+4 and `link_reg_o`=31.
- R8: A word with bits 31:26 = 000100 and `dec_rs_i` equal to `dec_rt_i` gives `calc_redir_o`=1 and `calc_tgt_o` = `dec_pc_i`+4 plus word bits 15:0 sign-extended and multiplied by 4.
- R9: A word with bits 31:26 = 000100 and unequal register values gives `calc_redir_o`=0. When this is fed back as the redirect, fetch continues sequentially.
- R10: Any other value of bits 31:26 gives `calc_redir_o`=0 and `link_wr_o`=0. When `calc_redir_o` is 0, `calc_tgt_o` is 0. When `link_wr_o` is 0, `link_val_o` and `link_reg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the fetch address |
| redir_i | input | 1 | Redirect fetch to redir_tgt_i |
| redir_tgt_i | input | 32 | Redirect target address |
| imem_addr_o | output | 32 | Instruction memory address |
| imem_en_o | output | 1 | Instruction memory enable |
| dec_word_i | input | 32 | Instruction word given to the target helper |
| dec_pc_i | input | 32 | Address of that instruction |
| dec_rs_i | input | 32 | First compared register value |
| dec_rt_i | input | 32 | Second compared register value |
| calc_redir_o | output | 1 | Helper requests a change of flow |
| calc_tgt_o | output | 32 | Helper target address |
| link_wr_o | output | 1 | Link register write request |
| link_val_o | output | 32 | Link value |
| link_reg_o | output | 5 | Link destination register number |

## Verification
The bench drives redirect and stall high together, to catch a design that lets the stall mask the redirect and so loses a taken branch. It also changes inputs on the first cycle after reset, because a counter that advances or redirects there would skip the instruction at the reset address. Branch offsets of -1 and of large magnitude expose a zero-extended or unshifted offset, which would send a backward loop forward. Jumps from addresses with high bits set, and unequal branches fed back as the redirect, expose a target that drops the upper region bits and a branch that is taken without checking equality.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam int XW      = 32;
  localparam int OPW     = 6;
  localparam int RW      = 5;
  localparam int IDXW    = 26;
  localparam int OFFW    = 16;
  localparam int REGIONW = XW - IDXW - 2;
  localparam logic [XW-1:0]  STEP     = XW'(4);
  localparam logic [OPW-1:0] OP_JMP   = 6'b000010;
  localparam logic [OPW-1:0] OP_CALL  = 6'b000011;
  localparam logic [OPW-1:0] OP_BREQ  = 6'b000100;
  localparam logic [RW-1:0]  LINK_REG = RW'(31);

  typedef enum logic [1:0] {K_OTHER, K_JMP, K_CALL, K_BREQ} flow_kind_e;

  function automatic logic [XW-1:0] seq_next(input logic [XW-1:0] pc);
    return pc + STEP;
  endfunction

  function automatic flow_kind_e kind_of(input logic [XW-1:0] word);
    case (word[XW-1 -: OPW])
      OP_JMP:  return K_JMP;
      OP_CALL: return K_CALL;
      OP_BREQ: return K_BREQ;
      default: return K_OTHER;
    endcase
  endfunction

  function automatic logic [XW-1:0] region_target(input logic [XW-1:0] nxt,
                                                  input logic [XW-1:0] word);
    return {nxt[XW-1 -: REGIONW], word[IDXW-1:0], 2'b00};
  endfunction

  function automatic logic [XW-1:0] rel_target(input logic [XW-1:0] nxt,
                                               input logic [XW-1:0] word);
    logic [XW-1:0] disp;
    disp = {{(XW-OFFW-2){word[OFFW-1]}}, word[OFFW-1:0], 2'b00};
    return nxt + disp;
  endfunction
endpackage

// File: rtl/fpc_target_calc.sv
`timescale 1ns/1ps
module fpc_target_calc
  import fpc_pkg::*;
(
  input  logic [XW-1:0] word_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] rs_i,
  input  logic [XW-1:0] rt_i,
  output logic          redir_o,
  output logic [XW-1:0] tgt_o,
  output logic          link_wr_o,
  output logic [XW-1:0] link_val_o,
  output logic [RW-1:0] link_reg_o
);
  flow_kind_e    kind;
  logic [XW-1:0] pc_next;
  logic          operands_equal;
  logic          is_abs;
  logic          is_rel_taken;

  assign kind           = kind_of(word_i);
  assign pc_next        = seq_next(pc_i);
  assign operands_equal = (rs_i == rt_i);
  assign is_abs         = (kind == K_JMP) || (kind == K_CALL);
  assign is_rel_taken   = (kind == K_BREQ) && operands_equal;

  always_comb begin
    redir_o    = 1'b0;
    tgt_o      = '0;
    link_wr_o  = 1'b0;
    link_val_o = '0;
    link_reg_o = '0;
    if (is_abs) begin
      redir_o = 1'b1;
      tgt_o   = region_target(pc_next, word_i);
    end else if (is_rel_taken) begin
      redir_o = 1'b1;
      tgt_o   = rel_target(pc_next, word_i);
    end
    if (kind == K_CALL) begin
      link_wr_o  = 1'b1;
      link_val_o = pc_next;
      link_reg_o = LINK_REG;
    end
  end

  always_comb begin
    if (is_abs)
      a_r6_region_kept: assert (tgt_o[XW-1 -: REGIONW] == pc_next[XW-1 -: REGIONW]
                                && tgt_o[1:0] == 2'b00);
    if (kind == K_BREQ && !operands_equal)
      a_r9_unequal_no_redirect: assert (!redir_o);
    if (link_wr_o)
      a_r7_link_is_call: assert (redir_o && link_reg_o == LINK_REG);
    if (!redir_o)
      a_r10_quiet_target: assert (tgt_o == '0 && !link_wr_o);
  end
endmodule

// File: rtl/fpc_pc_reg.sv
`timescale 1ns/1ps
module fpc_pc_reg
  import fpc_pkg::*;
#(
  parameter logic [XW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_i,
  input  logic          redir_i,
  input  logic [XW-1:0] tgt_i,
  output logic [XW-1:0] pc_o,
  output logic          en_o
);
  logic [XW-1:0] pc_q;
  logic          run_q;
  logic          take_redirect;
  logic          take_hold;

  assign take_redirect = run_q && redir_i;
  assign take_hold     = run_q && stall_i && !redir_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_ADDR;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (!run_q)             pc_q <= RESET_ADDR;
      else if (take_redirect) pc_q <= tgt_i;
      else if (!take_hold)    pc_q <= seq_next(pc_q);
    end
  end

  assign pc_o = pc_q;
  assign en_o = run_q;

  always_comb begin
    if (!run_q)
      a_r1_idle_at_reset_addr: assert (pc_q == RESET_ADDR || $isunknown(run_q));
  end

  a_r2_first_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> pc_q == RESET_ADDR);

  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (run_q && !redir_i && !stall_i) |=> pc_q == $past(pc_q) + STEP);

  a_r4_redirect_wins: assert property (@(posedge clk) disable iff (rst)
    (run_q && redir_i) |=> pc_q == $past(tgt_i));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (run_q && stall_i && !redir_i) |=> $stable(pc_q));
endmodule

// File: rtl/fetch_pc_unit.sv
`timescale 1ns/1ps
module fetch_pc_unit
  import fpc_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall_i,
  input  logic        redir_i,
  input  logic [31:0] redir_tgt_i,
  output logic [31:0] imem_addr_o,
  output logic        imem_en_o,
  input  logic [31:0] dec_word_i,
  input  logic [31:0] dec_pc_i,
  input  logic [31:0] dec_rs_i,
  input  logic [31:0] dec_rt_i,
  output logic        calc_redir_o,
  output logic [31:0] calc_tgt_o,
  output logic        link_wr_o,
  output logic [31:0] link_val_o,
  output logic [4:0]  link_reg_o
);
  fpc_pc_reg #(.RESET_ADDR(RESET_ADDR)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .stall_i (stall_i),
    .redir_i (redir_i),
    .tgt_i   (redir_tgt_i),
    .pc_o    (imem_addr_o),
    .en_o    (imem_en_o)
  );

  fpc_target_calc u_calc (
    .word_i     (dec_word_i),
    .pc_i       (dec_pc_i),
    .rs_i       (dec_rs_i),
    .rt_i       (dec_rt_i),
    .redir_o    (calc_redir_o),
    .tgt_o      (calc_tgt_o),
    .link_wr_o  (link_wr_o),
    .link_val_o (link_val_o),
    .link_reg_o (link_reg_o)
  );
endmodule

// File: tb/fetch_pc_unit_test.sv
`timescale 1ns/1ps
module fetch_pc_unit_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, stall = 1'b0, redir = 1'b0;
  logic [31:0] tgt = '0, word = '0, dpc = '0, rs = '0, rt = '0;
  logic [31:0] addr, c_tgt, l_val;
  logic        en, c_redir, l_wr;
  logic [4:0]  l_reg;

  fetch_pc_unit uut (
    .clk(clk), .rst(rst), .stall_i(stall), .redir_i(redir), .redir_tgt_i(tgt),
    .imem_addr_o(addr), .imem_en_o(en),
    .dec_word_i(word), .dec_pc_i(dpc), .dec_rs_i(rs), .dec_rt_i(rt),
    .calc_redir_o(c_redir), .calc_tgt_o(c_tgt),
    .link_wr_o(l_wr), .link_val_o(l_val), .link_reg_o(l_reg)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference of the fetch address
  logic [31:0] m_pc = 32'h0;
  bit          m_en = 0;
  string       m_tag = "R1";
  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_en = 0; m_tag = "R1";
    end else if (!m_en) begin
      m_en = 1; m_tag = "R2";
    end else if (redir) begin
      m_pc = tgt; m_tag = "R4";
    end else if (stall) begin
      m_tag = "R5";
    end else begin
      m_pc = m_pc + 32'd4; m_tag = "R3";
    end
  end

  task automatic cmp_fetch();
    check(en === m_en, {m_tag, " enable"}, {31'b0, en}, {31'b0, m_en});
    check(addr === m_pc, {m_tag, " address"}, addr, m_pc);
  endtask

  task automatic cmp_helper();
    logic [31:0] nx, e_tgt, e_lv;
    bit e_redir, e_lw;
    logic [4:0] e_lr;
    string tag;
    int off;
    nx = dpc + 32'd4;
    e_redir = 0; e_tgt = 0; e_lw = 0; e_lv = 0; e_lr = 0; tag = "R10";
    case (word[31:26])
      6'd2: begin tag = "R6"; e_redir = 1; e_tgt = (nx & 32'hF000_0000) | ((word & 32'h03FF_FFFF) << 2); end
      6'd3: begin tag = "R7"; e_redir = 1; e_tgt = (nx & 32'hF000_0000) | ((word & 32'h03FF_FFFF) << 2);
                  e_lw = 1; e_lv = nx; e_lr = 5'd31; end
      6'd4: begin
        if (rs == rt) begin
          tag = "R8"; e_redir = 1;
          off = int'($signed(word[15:0]));
          e_tgt = nx + 32'(off * 4);
        end else tag = "R9";
      end
      default: ;
    endcase
    check(c_redir === e_redir, {tag, " redirect"}, {31'b0, c_redir}, {31'b0, e_redir});
    check(c_tgt === e_tgt, {tag, " target"}, c_tgt, e_tgt);
    check(l_wr === e_lw, {tag, " link write"}, {31'b0, l_wr}, {31'b0, e_lw});
    check(l_val === e_lv, {tag, " link value"}, l_val, e_lv);
    check(l_reg === e_lr, {tag, " link reg"}, {27'b0, l_reg}, {27'b0, e_lr});
  endtask

  // one cycle: check fetch state, drive new inputs, check helper
  task automatic step(input bit r, input bit s, input bit d, input logic [31:0] t,
                      input logic [31:0] w, input logic [31:0] p, input logic [31:0] a,
                      input logic [31:0] b, input bit loop);
    @(negedge clk);
    cmp_fetch();
    rst = r; stall = s; word = w; dpc = p; rs = a; rt = b;
    redir = d; tgt = t;
    #1;
    cmp_helper();
    if (loop) begin redir = c_redir; tgt = c_tgt; end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    // R1 reset, with busy inputs that must not matter
    for (int i = 0; i < 3; i++) step(1, 1, 1, 32'h0000_0800, 0, 0, 0, 0, 0);
    // R2 first fetch ignores redirect and stall
    step(0, 1, 1, 32'h0000_0900, 0, 0, 0, 0, 0);
    // R3 sequential
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 stall
    for (int i = 0; i < 4; i++) step(0, 1, 0, 32'h0000_1234, 0, 0, 0, 0, 0);
    // R4 redirect together with stall
    step(0, 1, 1, 32'h0000_0100, 0, 0, 0, 0, 0);
    step(0, 0, 1, 32'hFFFF_FFF8, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0); // R3 wrap
    // helper fed back: R6 R7 R8 R9 R10
    step(0, 0, 0, 0, {6'd2, 26'h012_3456}, 32'hA040_0000, 0, 0, 1);
    step(0, 0, 0, 0, {6'd3, 26'h3FF_FFFF}, 32'h7000_0010, 0, 0, 1);
    step(0, 0, 0, 0, {6'd4, 10'h0, 16'hFFFF}, 32'h0040_0020, 32'h5, 32'h5, 1);
    step(0, 0, 0, 0, {6'd4, 10'h0, 16'h8000}, 32'h0040_0020, 32'h9, 32'h9, 1);
    step(0, 0, 0, 0, {6'd4, 10'h0, 16'h7FFF}, 32'h0040_0020, 32'h9, 32'h9, 1);
    step(0, 0, 0, 0, {6'd4, 10'h0, 16'h0010}, 32'h0040_0020, 32'h9, 32'h8, 1);
    step(0, 0, 0, 0, {6'd8, 26'h3FF_FFFF}, 32'h0040_0020, 32'h1, 32'h1, 1);
    step(0, 0, 0, 0, {6'd0, 26'h000_0020}, 32'h0040_0020, 32'h1, 32'h1, 1);
    // random mixed traffic, with a reset pulse in the middle
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 4));
      w = $urandom();
      w[31:26] = (k == 0) ? 6'd2 : (k == 1) ? 6'd3 : (k <= 3) ? 6'd4 : w[31:26];
      rs = $urandom_range(0, 3);
      step((i >= 300 && i < 302), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
           $urandom(), w, $urandom(), rs, 32'($urandom_range(0, 3)), (i % 3 == 0));
    end
    @(negedge clk);
    cmp_fetch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule